// File: doc/BRIEF.md
# Prioritized Trap Arbiter

This block sits between the sources that can raise a processor trap and the trap sequencer. In any cycle one trap request may arrive, carrying a type byte, an override byte and two small operands for software traps. The block works out the effective type byte, looks up its priority in a table held inside the block, and keeps only the most urgent request. Level interrupts are screened against the current trap-enable bit and interrupt level before they take part.

When the sequencer asks to take the queued trap, the block emits the winning type byte for one cycle, empties the queue, forces the committed trap-enable value low, captures the supervisor bit as the previous-supervisor value, and raises an issue stall for a fixed number of cycles. The priority table is written through a simple port, and only while the block is held in reset.

Top module: `trap_arbiter`

## Requirements
- R1: While and right after reset, pending, takenValid and stallIssue are 0, and etOut and psOut are 0.
- R2: The priority table has one 8-bit entry per type byte (256 entries); a write through tblWrEn/tblWrAddr/tblWrData is accepted only while rstN is 0 and ignored while rstN is 1.
- R3: A request whose priority is nonzero is queued when the queue is empty; a queued trap is replaced only by a request whose priority value is strictly smaller; pendType shows the queued type byte, one cycle after the request.
- R4: A request whose table entry is 0 is never queued.
- R5: Requests of type 17 to 30 (levels 1 to 14, level = type minus 16) are dropped when etIn is 0 or when the level is at most pilIn; type 31 (level 15) is never dropped by this check.
- R6: A request of type 128 is a software trap: its type byte is 128 plus the 7-bit sum of swOpA and swOpB (carry out discarded), and its priority is the table entry of that type byte.
- R7: A request of type 0 is a reset-class request: its priority is table entry 0 and its queued type byte is reqOverride.
- R8: takeReq while a trap is queued and no stall is active gives, one cycle later, takenValid for exactly one cycle with takenType equal to the queued type, the queue emptied, etOut 0 and psOut equal to sIn at the take; in every other cycle etOut takes the value etIn had one cycle earlier and psOut holds.
- R9: stallIssue is 1 for exactly 4 cycles starting the cycle after a take; takeReq during the stall, or with nothing queued, takes nothing.
- R10: A request arriving in the cycle a trap is taken is compared against an empty queue, so it is queued whatever the priority of the trap being taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low; table load window |
| tblWrEn | input | 1 | Priority table write strobe (reset only) |
| tblWrAddr | input | 8 | Table entry index (type byte) |
| tblWrData | input | 8 | Priority value to store |
| reqValid | input | 1 | Trap request strobe |
| reqType | input | 8 | Requested type code |
| reqOverride | input | 8 | Type byte used by a reset-class request |
| swOpA | input | 7 | First software-trap operand (low bits) |
| swOpB | input | 7 | Second software-trap operand (low bits) |
| etIn | input | 1 | Current trap-enable bit |
| pilIn | input | 4 | Current processor interrupt level |
| sIn | input | 1 | Current supervisor bit |
| takeReq | input | 1 | Sequencer asks to take the queued trap |
| pending | output | 1 | A trap is queued |
| pendType | output | 8 | Type byte of the queued trap |
| takenValid | output | 1 | One-cycle pulse: a trap was taken |
| takenType | output | 8 | Type byte of the trap taken |
| etOut | output | 1 | Trap-enable value to commit |
| psOut | output | 1 | Previous-supervisor value to commit |
| stallIssue | output | 1 | Instruction issue must wait |

## Verification
The bench builds the block with its default parameters: an 8-bit type byte and an 8-bit priority, so the full 256-entry table, the whole software-trap range 128 to 255 and interrupt level 15 are within reach, and a 4-cycle take stall short enough to step through edge by edge. It loads the table during reset from its own priority model, then drives requests that must win, lose or be screened, including a take coinciding with a fresh request and a table write attempted outside reset.

// File: rtl/trap_arb_pkg.sv
package trap_arb_pkg;

  // Type codes whose meaning the arbiter itself depends on
  localparam int TYPE_RESET   = 0;
  localparam int INT_BASE     = 16;   // level N arrives as INT_BASE + N
  localparam int INT_MASK_TOP = 14;   // highest level screened by ET/PIL
  localparam int TYPE_SWTRAP  = 128;

  // Strobes from control to datapath
  typedef struct packed {
    logic take;       // empty the queue this cycle
    logic captureOut; // latch queued type as the taken type
  } arbCtrl_t;

endpackage

// File: rtl/trap_prio_table.sv
module trap_prio_table #(
  parameter int TYPE_W = 8,
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [TYPE_W-1:0] wrAddr,
  input  logic [PRIO_W-1:0] wrData,
  input  logic [TYPE_W-1:0] rdAddr,
  output logic [PRIO_W-1:0] rdPrio
);
  localparam int DEPTH = 1 << TYPE_W;

  logic [PRIO_W-1:0] mem [DEPTH];

  // Loaded only while the block is held in reset
  always_ff @(posedge clk) begin
    if (!rstN && wrEn) mem[wrAddr] <= wrData;
  end

  assign rdPrio = mem[rdAddr];
endmodule

// File: rtl/trap_arb_dp.sv
module trap_arb_dp
  import trap_arb_pkg::*;
#(
  parameter int TYPE_W = 8,
  parameter int PRIO_W = 8,
  parameter int LVL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbCtrl_t          ctrl,
  input  logic              reqValid,
  input  logic [TYPE_W-1:0] reqType,
  input  logic [TYPE_W-1:0] reqOverride,
  input  logic [TYPE_W-2:0] swOpA,
  input  logic [TYPE_W-2:0] swOpB,
  input  logic              etIn,
  input  logic [LVL_W-1:0]  pilIn,
  output logic [TYPE_W-1:0] lookupType,
  input  logic [PRIO_W-1:0] lookupPrio,
  output logic              pendValid,
  output logic [TYPE_W-1:0] pendType,
  output logic [TYPE_W-1:0] takenType
);
  localparam logic [TYPE_W-1:0] T_RESET = TYPE_W'(TYPE_RESET);
  localparam logic [TYPE_W-1:0] T_SW    = TYPE_W'(TYPE_SWTRAP);
  localparam logic [TYPE_W-1:0] T_ILO   = TYPE_W'(INT_BASE + 1);
  localparam logic [TYPE_W-1:0] T_IHI   = TYPE_W'(INT_BASE + INT_MASK_TOP);
  localparam logic [TYPE_W-1:0] T_IBASE = TYPE_W'(INT_BASE);

  logic [PRIO_W-1:0] pendPrio;
  logic [TYPE_W-2:0] swSum;
  logic [TYPE_W-1:0] effType;
  logic [TYPE_W-1:0] level;
  logic              maskable, masked, candOk, win;
  logic [PRIO_W-1:0] basePrio;

  // Effective type byte of the incoming request
  always_comb begin
    swSum = swOpA + swOpB;
    if (reqType == T_RESET)      effType = reqOverride;
    else if (reqType == T_SW)    effType = {1'b1, swSum};
    else                         effType = reqType;
    // reset class always ranks by entry 0
    lookupType = (reqType == T_RESET) ? T_RESET : effType;
  end

  // Interrupt screening and priority comparison
  always_comb begin
    level    = reqType - T_IBASE;
    maskable = (reqType >= T_ILO) && (reqType <= T_IHI);
    masked   = maskable && (!etIn || (level <= TYPE_W'(pilIn)));
    candOk   = reqValid && !masked && (lookupPrio != '0);
    basePrio = ctrl.take ? '0 : pendPrio;
    win      = candOk && ((basePrio == '0) || (lookupPrio < basePrio));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendPrio  <= '0;
      pendType  <= '0;
      takenType <= '0;
    end else begin
      if (ctrl.captureOut) takenType <= pendType;
      if (win) begin
        pendPrio <= lookupPrio;
        pendType <= effType;
      end else if (ctrl.take) begin
        pendPrio <= '0;
        pendType <= '0;
      end
    end
  end

  assign pendValid = (pendPrio != '0);
endmodule

// File: rtl/trap_arb_ctrl.sv
module trap_arb_ctrl
  import trap_arb_pkg::*;
#(
  parameter int TAKE_CYCLES = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     takeReq,
  input  logic     pendValid,
  input  logic     etIn,
  input  logic     sIn,
  output arbCtrl_t ctrl,
  output logic     takenValid,
  output logic     etOut,
  output logic     psOut,
  output logic     stallIssue
);
  localparam int CNT_W = $clog2(TAKE_CYCLES + 1);

  logic [CNT_W-1:0] stallCnt;
  logic             takeNow;

  always_comb begin
    takeNow         = takeReq && pendValid && (stallCnt == '0);
    ctrl.take       = takeNow;
    ctrl.captureOut = takeNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stallCnt   <= '0;
      takenValid <= 1'b0;
      etOut      <= 1'b0;
      psOut      <= 1'b0;
    end else begin
      takenValid <= takeNow;
      if (takeNow) begin
        stallCnt <= CNT_W'(TAKE_CYCLES);
        etOut    <= 1'b0;
        psOut    <= sIn;
      end else begin
        if (stallCnt != '0) stallCnt <= stallCnt - 1'b1;
        etOut <= etIn;
      end
    end
  end

  assign stallIssue = (stallCnt != '0);
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_arb_pkg::*;
#(
  parameter int TYPE_W      = 8,
  parameter int PRIO_W      = 8,
  parameter int LVL_W       = 4,
  parameter int TAKE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tblWrEn,
  input  logic [TYPE_W-1:0] tblWrAddr,
  input  logic [PRIO_W-1:0] tblWrData,
  input  logic              reqValid,
  input  logic [TYPE_W-1:0] reqType,
  input  logic [TYPE_W-1:0] reqOverride,
  input  logic [TYPE_W-2:0] swOpA,
  input  logic [TYPE_W-2:0] swOpB,
  input  logic              etIn,
  input  logic [LVL_W-1:0]  pilIn,
  input  logic              sIn,
  input  logic              takeReq,
  output logic              pending,
  output logic [TYPE_W-1:0] pendType,
  output logic              takenValid,
  output logic [TYPE_W-1:0] takenType,
  output logic              etOut,
  output logic              psOut,
  output logic              stallIssue
);
  arbCtrl_t          ctrl;
  logic [TYPE_W-1:0] lookupType;
  logic [PRIO_W-1:0] lookupPrio;

  trap_prio_table #(.TYPE_W(TYPE_W), .PRIO_W(PRIO_W)) u_table (
    .clk(clk), .rstN(rstN), .wrEn(tblWrEn), .wrAddr(tblWrAddr),
    .wrData(tblWrData), .rdAddr(lookupType), .rdPrio(lookupPrio)
  );

  trap_arb_dp #(.TYPE_W(TYPE_W), .PRIO_W(PRIO_W), .LVL_W(LVL_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .reqValid(reqValid),
    .reqType(reqType), .reqOverride(reqOverride), .swOpA(swOpA),
    .swOpB(swOpB), .etIn(etIn), .pilIn(pilIn), .lookupType(lookupType),
    .lookupPrio(lookupPrio), .pendValid(pending), .pendType(pendType),
    .takenType(takenType)
  );

  trap_arb_ctrl #(.TAKE_CYCLES(TAKE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .takeReq(takeReq), .pendValid(pending),
    .etIn(etIn), .sIn(sIn), .ctrl(ctrl), .takenValid(takenValid),
    .etOut(etOut), .psOut(psOut), .stallIssue(stallIssue)
  );
endmodule

// File: rtl/trap_arbiter_chk.sv
module trap_arbiter_chk #(
  parameter int TAKE_CYCLES = 4
) (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic takeReq,
  input logic sIn,
  input logic pending,
  input logic takenValid,
  input logic etOut,
  input logic psOut,
  input logic stallIssue
);
  localparam int RUN_W = $clog2(TAKE_CYCLES + 2);

  logic [RUN_W-1:0] stallRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           stallRun <= '0;
    else if (!stallIssue) stallRun <= '0;
    else                 stallRun <= stallRun + 1'b1;
  end

  AST_TAKE_ET_LOW: assert property (@(posedge clk) disable iff (!rstN)
    takenValid |-> !etOut); // R8
  AST_TAKE_PS_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    takenValid |-> psOut == $past(sIn)); // R8
  AST_TAKE_NEEDS_QUEUE: assert property (@(posedge clk) disable iff (!rstN)
    takenValid |-> $past(pending) && $past(takeReq)); // R8
  AST_TAKE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    takenValid |=> !takenValid); // R9
  AST_TAKE_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    takenValid |-> stallIssue); // R9
  AST_STALL_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stallIssue) |-> stallRun == RUN_W'(TAKE_CYCLES)); // R9
  AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    stallIssue |-> stallRun < RUN_W'(TAKE_CYCLES)); // R9
  AST_QUEUE_FROM_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending) |-> $past(reqValid)); // R3
endmodule

bind trap_arbiter trap_arbiter_chk #(.TAKE_CYCLES(TAKE_CYCLES)) i_chk (.*);

// File: tb/test_trap_arbiter.sv
module test_trap_arbiter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tblWrEn = 1'b0;
  logic [7:0] tblWrAddr = '0;
  logic [7:0] tblWrData = '0;
  logic       reqValid = 1'b0;
  logic [7:0] reqType = '0;
  logic [7:0] reqOverride = '0;
  logic [6:0] swOpA = '0;
  logic [6:0] swOpB = '0;
  logic       etIn = 1'b1;
  logic [3:0] pilIn = '0;
  logic       sIn = 1'b1;
  logic       takeReq = 1'b0;
  logic       pending;
  logic [7:0] pendType;
  logic       takenValid;
  logic [7:0] takenType;
  logic       etOut;
  logic       psOut;
  logic       stallIssue;

  int checks = 0;
  int errors = 0;

  trap_arbiter i_trap_arbiter (.*);

  always #5 clk = ~clk;

  // Bench priority model: smaller value is more urgent, 0 disables
  function automatic logic [7:0] prioOf(input int t);
    if (t <= 10) return 8'(t + 1);
    if (t >= 17 && t <= 31) return 8'(56 - t);
    if (t >= 128) return 8'd60;
    return 8'd0;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic req(input int t, input int ovr = 0, input int a = 0, input int b = 0);
    reqValid = 1'b1; reqType = 8'(t); reqOverride = 8'(ovr);
    swOpA = 7'(a); swOpB = 7'(b);
    cyc();
    reqValid = 1'b0;
  endtask

  task automatic flush();
    takeReq = 1'b1;
    cyc();
    takeReq = 1'b0;
    repeat (4) cyc();
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    @(negedge clk);
    for (int t = 0; t < 256; t++) begin
      tblWrEn = 1'b1; tblWrAddr = 8'(t); tblWrData = prioOf(t);
      cyc();
    end
    tblWrEn = 1'b0;
    chk(!pending && !takenValid && !stallIssue, "R1 idle in reset", pending, 0);
    rstN = 1'b1;
    #1;
    chk(!pending && !takenValid && !stallIssue, "R1 idle after release", stallIssue, 0);
    chk(!etOut && !psOut, "R1 et/ps cleared", {etOut, psOut}, 0);
    cyc();
  endtask

  task automatic t_merge();
    req(7);
    chk(pending && pendType == 8'd7, "R3 first request queued", pendType, 7);
    req(9);
    chk(pendType == 8'd7, "R3 less urgent loses", pendType, 7);
    req(2);
    chk(pendType == 8'd2, "R3 more urgent replaces", pendType, 2);
    req(8);
    chk(pendType == 8'd2, "R3 less urgent loses again", pendType, 2);
    sIn = 1'b1;
    takeReq = 1'b1;
    cyc();
    takeReq = 1'b0;
    chk(takenValid && takenType == 8'd2, "R8 taken type", takenType, 2);
    chk(!pending, "R8 queue emptied", pending, 0);
    chk(!etOut && psOut, "R8 et low ps from s", {etOut, psOut}, 1);
    chk(stallIssue, "R9 stall after take", stallIssue, 1);
    cyc();
    chk(!takenValid, "R8 single pulse", takenValid, 0);
    chk(etOut == etIn, "R8 et follows input", etOut, etIn);
    repeat (3) cyc();
    chk(!stallIssue, "R9 stall ends after 4", stallIssue, 0);
  endtask

  task automatic t_zero_prio();
    req(11);
    chk(!pending, "R4 zero-priority type dropped", pending, 0);
  endtask

  task automatic t_interrupts();
    etIn = 1'b0; pilIn = 4'd0;
    req(20);
    chk(!pending, "R5 level dropped with ET off", pending, 0);
    etIn = 1'b1; pilIn = 4'd4;
    req(20);
    chk(!pending, "R5 level equal to PIL dropped", pending, 0);
    req(21);
    chk(pending && pendType == 8'd21, "R5 level above PIL queued", pendType, 21);
    etIn = 1'b0;
    req(31);
    chk(pending && pendType == 8'd31, "R5 level 15 ignores ET", pendType, 31);
    etIn = 1'b1; pilIn = 4'd0;
    flush();
  endtask

  task automatic t_software();
    req(128, 0, 7'h05, 7'h7f);
    chk(pendType == 8'd132, "R6 sum wraps in 7 bits", pendType, 132);
    flush();
    req(128, 0, 7'h40, 7'h3f);
    chk(pendType == 8'd255, "R6 top software type", pendType, 255);
    flush();
  endtask

  task automatic t_reset_class();
    req(2);
    req(0, 8'h55);
    chk(pendType == 8'h55, "R7 override as type, wins", pendType, 'h55);
    req(1);
    chk(pendType == 8'h55, "R7 keeps entry-0 priority", pendType, 'h55);
  endtask

  task automatic t_same_cycle();
    // queued 0x55 (most urgent); take and request type 9 together
    sIn = 1'b0;
    takeReq = 1'b1;
    reqValid = 1'b1; reqType = 8'd9;
    cyc();
    reqValid = 1'b0;
    chk(takenValid && takenType == 8'h55, "R8 taken reset-class", takenType, 'h55);
    chk(!psOut, "R8 ps captures s=0", psOut, 0);
    chk(pending && pendType == 8'd9, "R10 request vs empty queue", pendType, 9);
    for (int k = 1; k <= 4; k++) begin
      cyc();
      chk(!takenValid, "R9 no take during stall", takenValid, 0);
      chk(stallIssue == (k < 4), "R9 stall length", stallIssue, k < 4);
    end
    cyc();
    chk(takenValid && takenType == 8'd9, "R9 take after stall", takenType, 9);
    takeReq = 1'b0;
    repeat (4) cyc();
    sIn = 1'b1;
  endtask

  task automatic t_empty_take();
    takeReq = 1'b1;
    cyc();
    takeReq = 1'b0;
    chk(!takenValid && !stallIssue, "R9 take with empty queue", takenValid, 0);
  endtask

  task automatic t_table_locked();
    tblWrEn = 1'b1; tblWrAddr = 8'd10; tblWrData = 8'd1;
    cyc();
    tblWrEn = 1'b0;
    req(9);
    req(10);
    chk(pendType == 8'd9, "R2 write outside reset ignored", pendType, 9);
    flush();
  endtask

  initial begin
    #2ms;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_merge();
    t_zero_prio();
    t_interrupts();
    t_software();
    t_reset_class();
    t_same_cycle();
    t_empty_take();
    t_table_locked();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule